// File: doc/BRIEF.md
# Single-Phase D-Q Voltage Regulator with Harmonic Injection PWM

This block closes the fundamental-frequency voltage and current loops of a single-phase inverter in a rotating d-q frame and turns the result into complementary gate drive. An upstream observer supplies the in-phase and quadrature fundamental components of the load voltage and load current, together with the voltage harmonic residue. All of these signals are 18-bit signed fixed point with 15 fraction bits (1.0 = 32768). The block makes its own unit sine and cosine references from a phase counter and a computed sine table. It projects the voltage and current pairs onto those references and regulates the voltage d and q values toward their set points with two PI controllers. The PI outputs act as current set points for two proportional current controllers.

The two current-controller outputs are mapped back into the time domain, and the in-phase and quadrature time signals are summed. The voltage harmonic residue, multiplied by a large feedback gain, is added to that sum so that the modulator cancels the distortion that nonlinear load currents would otherwise produce. The total is limited to plus or minus one. A symmetric triangular carrier derived from the 4 MHz clock produces the high-side and low-side gate signals. All controller arithmetic runs once per 12.8 kHz sample strobe. The carrier and the comparator run on every clock.

Top module: `dqc_top`

## Requirements
- R1: While reset is held, pwm_cmd = 0, gate_hi = 0, gate_lo = 1, ref_sin = 0, ref_cos = 32767 and carrier = -32768.
- R2: sample_en is high for exactly one clock, once every 313 clocks.
- R3: Table entry k is round(32767·sin(2πk/256)). ref_sin is the entry at the 8-bit phase p, and ref_cos is the entry at (p+64) mod 256. The phase starts at 0 after reset and advances by one on each sample_en, wrapping after 255.
- R4: With s = ref_sin and c = ref_cos, each pair (a,b) maps to d = (s·a + c·b) >>> 15 and q = (c·a − s·b) >>> 15. The shift is an arithmetic (floor) shift. This is done for the voltage pair and the current pair, and every intermediate result saturates to the 18-bit signed range.
- R5: Each voltage error e = ref − measured gives a current set point sat((18350·e >>> 15) + I). Here I is the integrator value before the update. On each sample_en, I becomes I + (207·e >>> 15), clamped to [−32768, 32767]. I does not change between strobes.
- R6: Each current error is multiplied by 49152 (1.5) and shifted right by 15 to give u_d and u_q. The time signal is the in-phase term (s·u_d + c·u_q) >>> 15 plus the quadrature term (c·u_d − s·u_q) >>> 15.
- R7: On each sample_en, pwm_cmd takes the R6 time signal plus 20·v_harm, using the inputs and references present in that cycle. pwm_cmd holds its value between strobes.
- R8: pwm_cmd is limited to [−32768, 32767].
- R9: A triangle count runs 0,1,…,200,199,…,1,0,… with one step per clock, so one period is 400 clocks. carrier = floor(count·65536/200) − 32768, so it spans −32768 to +32768.
- R10: gate_hi is registered as (pwm_cmd > carrier) from the previous clock, and gate_lo is its complement. With pwm_cmd = 0, gate_hi is high for 199 of every 400 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz control clock |
| rst | input | 1 | Synchronous active-high reset |
| v_inph | input | 18 | Fundamental voltage, in-phase component |
| v_quad | input | 18 | Fundamental voltage, quadrature component |
| i_inph | input | 18 | Fundamental current, in-phase component |
| i_quad | input | 18 | Fundamental current, quadrature component |
| v_harm | input | 18 | Voltage harmonic residue |
| vd_ref | input | 18 | Voltage d-axis set point |
| vq_ref | input | 18 | Voltage q-axis set point |
| sample_en | output | 1 | 12.8 kHz sample strobe |
| ref_sin | output | 18 | Unit sine reference |
| ref_cos | output | 18 | Unit cosine reference |
| pwm_cmd | output | 18 | Limited modulator command |
| carrier | output | 18 | Triangular carrier |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
The first pattern drives only the harmonic input, with small, over-range positive and over-range negative values. This separates the injection gain from the limiter on both rails. The second pattern uses large opposite-sign voltage set points with zero feedback. It runs the integrators into their clamps and then removes the error, which shows whether the clamped value, rather than a wound-up one, drives the command. The third pattern sets every input to a distinct nonzero value. Across ten strobes of advancing phase, this exposes any swapped sine or cosine term or sign in either Park transform. A final run with a zero command follows the carrier through one full period and counts gate duty, which pins down the triangle turning points and the strict comparison.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

    localparam int W    = 18;
    localparam int FRAC = 15;

    typedef logic signed [W-1:0]  q_t;
    typedef logic signed [47:0]   acc_t;

    typedef struct packed {
        q_t d;
        q_t q;
    } dq_t;

    typedef struct packed {
        q_t s;
        q_t c;
    } unit_ref_t;

    function automatic acc_t wide(input q_t x);
        return {{(48-W){x[W-1]}}, x};
    endfunction

    function automatic q_t sat_w(input acc_t x);
        if (x > 48'sd131071)       return 18'sd131071;
        else if (x < -48'sd131072) return -18'sd131072;
        return x[W-1:0];
    endfunction

    function automatic q_t clamp_unit(input acc_t x);
        if (x > 48'sd32767)       return 18'sd32767;
        else if (x < -48'sd32768) return -18'sd32768;
        return x[W-1:0];
    endfunction

    function automatic q_t mul_q(input q_t a, input q_t b);
        return sat_w((wide(a) * wide(b)) >>> FRAC);
    endfunction

    function automatic dq_t park_fwd(input unit_ref_t r, input q_t a, input q_t b);
        dq_t o;
        o.d = sat_w((wide(r.s) * wide(a) + wide(r.c) * wide(b)) >>> FRAC);
        o.q = sat_w((wide(r.c) * wide(a) - wide(r.s) * wide(b)) >>> FRAC);
        return o;
    endfunction

    function automatic acc_t park_inv_sum(input unit_ref_t r, input dq_t u);
        q_t inph, quad;
        inph = sat_w((wide(r.s) * wide(u.d) + wide(r.c) * wide(u.q)) >>> FRAC);
        quad = sat_w((wide(r.c) * wide(u.d) - wide(r.s) * wide(u.q)) >>> FRAC);
        return wide(inph) + wide(quad);
    endfunction

    function automatic q_t sine_entry(input int k, input int depth);
        real r;
        r = 32767.0 * $sin(6.283185307179586 * real'(k) / real'(depth));
        return q_t'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
    endfunction

    function automatic q_t tri_to_q(input int cnt, input int half);
        return q_t'((cnt * 65536) / half - 32768);
    endfunction

endpackage

// File: rtl/dqc_timebase.sv
module dqc_timebase
    import dqc_pkg::*;
#(
    parameter int DIV        = 313,
    parameter int PHASE_W    = 8,
    parameter int HALF_STEPS = 200
) (
    input  logic               clk,
    input  logic               rst,
    output logic               sample_en,
    output logic [PHASE_W-1:0] phase,
    output q_t                 carrier
);
    localparam int PW = $clog2(DIV);
    localparam int CW = $clog2(HALF_STEPS + 1);

    logic [PW-1:0] pre_cnt;
    logic [CW-1:0] tri_cnt;
    logic          tri_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt   <= '0;
            sample_en <= 1'b0;
            phase     <= '0;
        end else begin
            pre_cnt   <= (pre_cnt == PW'(DIV - 1)) ? '0 : pre_cnt + 1'b1;
            sample_en <= (pre_cnt == PW'(DIV - 1));
            if (sample_en) phase <= phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tri_cnt <= '0;
            tri_up  <= 1'b1;
        end else if (tri_up) begin
            tri_cnt <= tri_cnt + 1'b1;
            if (tri_cnt == CW'(HALF_STEPS - 1)) tri_up <= 1'b0;
        end else begin
            tri_cnt <= tri_cnt - 1'b1;
            if (tri_cnt == CW'(1)) tri_up <= 1'b1;
        end
    end

    assign carrier = tri_to_q(int'(tri_cnt), HALF_STEPS);

    // R2: strobe never lasts two clocks
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en);

    // R3: phase steps by one on a strobe and holds otherwise
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> phase == $past(phase) + 1'b1);
    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(phase));

    // R9: triangle count stays in range and moves one step per clock
    p_tri_range_r9: assert property (@(posedge clk) disable iff (rst)
        tri_cnt <= CW'(HALF_STEPS));
    p_tri_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tri_cnt == $past(tri_cnt) + 1'b1) || (tri_cnt == $past(tri_cnt) - 1'b1));
endmodule

// File: rtl/dqc_sine_ref.sv
module dqc_sine_ref
    import dqc_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic [PHASE_W-1:0] phase,
    output unit_ref_t          uref
);
    localparam int DEPTH = 1 << PHASE_W;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(DEPTH / 4);

    q_t table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tab
        localparam q_t VAL = sine_entry(k, DEPTH);
        assign table_w[k] = VAL;
    end

    logic [PHASE_W-1:0] cos_idx;
    assign cos_idx = phase + QUARTER;
    assign uref.s  = table_w[phase];
    assign uref.c  = table_w[cos_idx];
endmodule

// File: rtl/dqc_pi.sv
module dqc_pi
    import dqc_pkg::*;
#(
    parameter int KP_Q = 18350,
    parameter int KI_Q = 207
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  q_t   err,
    output q_t   out
);
    q_t integ;

    assign out = sat_w(wide(mul_q(q_t'(KP_Q), err)) + wide(integ));

    always_ff @(posedge clk) begin
        if (rst)     integ <= '0;
        else if (en) integ <= clamp_unit(wide(integ) + wide(mul_q(q_t'(KI_Q), err)));
    end

    // R5: integrator remains inside its anti-windup bounds
    p_integ_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (integ >= -18'sd32768) && (integ <= 18'sd32767));
    // R5: integrator only moves on a strobe
    p_integ_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(integ));
endmodule

// File: rtl/dqc_pwm.sv
module dqc_pwm
    import dqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  q_t   cmd,
    input  q_t   carrier,
    output logic gate_hi,
    output logic gate_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b1;
        end else begin
            gate_hi <= (cmd > carrier);
            gate_lo <= !(cmd > carrier);
        end
    end

    // R10: high side on only if the command led the carrier one clock earlier
    p_gate_cmp_r10: assert property (@(posedge clk) disable iff (rst)
        gate_hi |-> $past(cmd) > $past(carrier));
    p_gate_compl_r10: assert property (@(posedge clk) disable iff (rst)
        gate_hi != gate_lo);
endmodule

// File: rtl/dqc_top.sv
module dqc_top
    import dqc_pkg::*;
#(
    parameter int DIV        = 313,
    parameter int PHASE_W    = 8,
    parameter int HALF_STEPS = 200,
    parameter int KP_Q       = 18350,
    parameter int KI_Q       = 207,
    parameter int KC_Q       = 49152,
    parameter int H_GAIN     = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [17:0]  v_inph,
    input  logic signed [17:0]  v_quad,
    input  logic signed [17:0]  i_inph,
    input  logic signed [17:0]  i_quad,
    input  logic signed [17:0]  v_harm,
    input  logic signed [17:0]  vd_ref,
    input  logic signed [17:0]  vq_ref,
    output logic                sample_en,
    output logic signed [17:0]  ref_sin,
    output logic signed [17:0]  ref_cos,
    output logic signed [17:0]  pwm_cmd,
    output logic signed [17:0]  carrier,
    output logic                gate_hi,
    output logic                gate_lo
);
    logic [PHASE_W-1:0] phase;
    unit_ref_t          uref;
    dq_t                v_dq, i_dq, v_err, i_set, u_dq;
    q_t                 err_ax  [2];
    q_t                 iset_ax [2];
    acc_t               u_sum;
    q_t                 cmd_next;
    q_t                 cmd_q;

    dqc_timebase #(.DIV(DIV), .PHASE_W(PHASE_W), .HALF_STEPS(HALF_STEPS)) u_tb (
        .clk(clk), .rst(rst), .sample_en(sample_en), .phase(phase), .carrier(carrier)
    );

    dqc_sine_ref #(.PHASE_W(PHASE_W)) u_ref (.phase(phase), .uref(uref));

    assign ref_sin = uref.s;
    assign ref_cos = uref.c;

    always_comb begin
        v_dq    = park_fwd(uref, v_inph, v_quad);
        i_dq    = park_fwd(uref, i_inph, i_quad);
        v_err.d = sat_w(wide(vd_ref) - wide(v_dq.d));
        v_err.q = sat_w(wide(vq_ref) - wide(v_dq.q));
    end

    assign err_ax[0] = v_err.d;
    assign err_ax[1] = v_err.q;

    for (genvar ax = 0; ax < 2; ax++) begin : g_vloop
        dqc_pi #(.KP_Q(KP_Q), .KI_Q(KI_Q)) u_pi (
            .clk(clk), .rst(rst), .en(sample_en),
            .err(err_ax[ax]), .out(iset_ax[ax])
        );
    end

    always_comb begin
        i_set.d  = iset_ax[0];
        i_set.q  = iset_ax[1];
        u_dq.d   = mul_q(q_t'(KC_Q), sat_w(wide(i_set.d) - wide(i_dq.d)));
        u_dq.q   = mul_q(q_t'(KC_Q), sat_w(wide(i_set.q) - wide(i_dq.q)));
        u_sum    = park_inv_sum(uref, u_dq);
        cmd_next = clamp_unit(u_sum + wide(v_harm) * 48'(H_GAIN));
    end

    always_ff @(posedge clk) begin
        if (rst)            cmd_q <= '0;
        else if (sample_en) cmd_q <= cmd_next;
    end

    assign pwm_cmd = cmd_q;

    dqc_pwm u_pwm (
        .clk(clk), .rst(rst), .cmd(cmd_q), .carrier(carrier),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // R7: command only changes on a sample strobe
    p_cmd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(pwm_cmd));
    // R8: command stays within the unit range
    p_cmd_range_r8: assert property (@(posedge clk) disable iff (rst)
        (pwm_cmd >= -18'sd32768) && (pwm_cmd <= 18'sd32767));
endmodule

// File: tb/tb_dqc_top.sv
`timescale 1ns/1ps
module tb_dqc_top;
    localparam int CLK_PERIOD = 250;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [17:0] v_inph = '0, v_quad = '0, i_inph = '0, i_quad = '0;
    logic signed [17:0] v_harm = '0, vd_ref = '0, vq_ref = '0;
    logic sample_en, gate_hi, gate_lo;
    logic signed [17:0] ref_sin, ref_cos, pwm_cmd, carrier;

    int checks = 0;
    int failures = 0;

    longint m_int_d, m_int_q;
    int     m_phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqc_top dut (
        .clk(clk), .rst(rst), .v_inph(v_inph), .v_quad(v_quad),
        .i_inph(i_inph), .i_quad(i_quad), .v_harm(v_harm),
        .vd_ref(vd_ref), .vq_ref(vq_ref), .sample_en(sample_en),
        .ref_sin(ref_sin), .ref_cos(ref_cos), .pwm_cmd(pwm_cmd),
        .carrier(carrier), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat18(input longint x);
        if (x > 131071) return 131071;
        if (x < -131072) return -131072;
        return x;
    endfunction

    function automatic longint unit_lim(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint mq(input longint a, input longint b);
        return sat18((a * b) >>> 15);
    endfunction

    function automatic longint lut(input int k);
        real r;
        r = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(k % 256) / 256.0);
        return longint'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
    endfunction

    function automatic longint tri_val(input int cnt);
        return longint'((cnt * 65536) / 200 - 32768);
    endfunction

    task automatic set_inputs(input int va, input int vb, input int ia, input int ib,
                              input int h, input int rd, input int rq);
        v_inph = 18'(va); v_quad = 18'(vb); i_inph = 18'(ia); i_quad = 18'(ib);
        v_harm = 18'(h);  vd_ref = 18'(rd); vq_ref = 18'(rq);
    endtask

    task automatic do_reset(input bit check_state);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        if (check_state) begin
            chk(pwm_cmd == 0, "R1 pwm_cmd", pwm_cmd, 0);
            chk(gate_hi == 1'b0 && gate_lo == 1'b1, "R1 gates", {gate_hi, gate_lo}, 1);
            chk(ref_sin == 0, "R1 ref_sin", ref_sin, 0);
            chk(ref_cos == 32767, "R1 ref_cos", ref_cos, 32767);
            chk(carrier == -32768, "R1 carrier", carrier, -32768);
        end
        rst = 1'b0;
        m_phase = 0; m_int_d = 0; m_int_q = 0;
    endtask

    // Runs n strobes, checking references (R3) and the resulting command against the model.
    task automatic run_strobes(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            longint s, c, vd, vq, id, iq, ed, eq, sd, sq, ud, uq, ti, tq, expc, nd, nq;
            do @(negedge clk); while (sample_en !== 1'b1);
            s = lut(m_phase); c = lut(m_phase + 64);
            chk(ref_sin == s, "R3 sin", ref_sin, s);
            chk(ref_cos == c, "R3 cos", ref_cos, c);
            // R4 forward Park of voltage and current
            vd = sat18((s * v_inph + c * v_quad) >>> 15);
            vq = sat18((c * v_inph - s * v_quad) >>> 15);
            id = sat18((s * i_inph + c * i_quad) >>> 15);
            iq = sat18((c * i_inph - s * i_quad) >>> 15);
            // R5 PI with old integrator
            ed = sat18(longint'(vd_ref) - vd);
            eq = sat18(longint'(vq_ref) - vq);
            sd = sat18(mq(18350, ed) + m_int_d);
            sq = sat18(mq(18350, eq) + m_int_q);
            nd = unit_lim(m_int_d + mq(207, ed));
            nq = unit_lim(m_int_q + mq(207, eq));
            // R6 proportional current loop and inverse Park sum
            ud = mq(49152, sat18(sd - id));
            uq = mq(49152, sat18(sq - iq));
            ti = sat18((s * ud + c * uq) >>> 15);
            tq = sat18((c * ud - s * uq) >>> 15);
            // R7 harmonic injection, R8 limit
            expc = unit_lim(ti + tq + 20 * longint'(v_harm));
            @(negedge clk);
            chk(pwm_cmd == expc, tag, pwm_cmd, expc);
            m_int_d = nd; m_int_q = nq;
            m_phase = (m_phase + 1) % 256;
        end
    endtask

    task automatic t_reset;
        set_inputs(0, 0, 0, 0, 0, 0, 0);
        do_reset(1'b1);
    endtask

    task automatic t_strobe;
        int gap;
        do_reset(1'b0);
        do @(negedge clk); while (sample_en !== 1'b1);
        @(negedge clk);
        chk(sample_en == 1'b0, "R2 single-cycle strobe", sample_en, 0);
        gap = 1;
        while (sample_en !== 1'b1 && gap < 1000) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == 313, "R2 strobe spacing", gap, 313);
        chk(ref_sin == lut(1), "R3 phase advanced", ref_sin, lut(1));
    endtask

    task automatic t_harmonic;
        do_reset(1'b0);
        set_inputs(0, 0, 0, 0, 1000, 0, 0);
        run_strobes(2, "R7 harmonic gain");
        set_inputs(0, 0, 0, 0, 1700, 0, 0);
        run_strobes(2, "R8 upper limit");
        chk(pwm_cmd == 32767, "R8 upper rail", pwm_cmd, 32767);
        set_inputs(0, 0, 0, 0, -1700, 0, 0);
        run_strobes(2, "R8 lower limit");
        chk(pwm_cmd == -32768, "R8 lower rail", pwm_cmd, -32768);
        // R7 hold between strobes
        repeat (100) @(negedge clk);
        chk(pwm_cmd == -32768, "R7 hold", pwm_cmd, -32768);
    endtask

    task automatic t_windup;
        do_reset(1'b0);
        set_inputs(0, 0, 0, 0, 0, 100000, -100000);
        run_strobes(60, "R5 integrator windup");
        set_inputs(0, 0, 0, 0, 0, 0, 0);
        run_strobes(6, "R5 clamped integrator release");
    endtask

    task automatic t_full;
        do_reset(1'b0);
        set_inputs(9000, -4000, 4000, -3000, 150, 12000, -2000);
        run_strobes(10, "R4 R6 full loop");
        set_inputs(-6000, 7000, -2500, 5000, -80, -3000, 8000);
        run_strobes(10, "R4 R6 full loop pattern 2");
    endtask

    task automatic t_carrier;
        int cnt_e, up_e, highs, bad_c, bad_g;
        longint prev_cmd, prev_car;
        set_inputs(0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        prev_cmd = pwm_cmd; prev_car = carrier;
        cnt_e = 1; up_e = 1; highs = 0; bad_c = 0; bad_g = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (carrier != tri_val(cnt_e)) bad_c++;
            if (gate_hi != (prev_cmd > prev_car) || gate_lo == gate_hi) bad_g++;
            if (gate_hi) highs++;
            prev_cmd = pwm_cmd; prev_car = carrier;
            if (up_e == 1) begin
                cnt_e++;
                if (cnt_e == 200) up_e = 0;
            end else begin
                cnt_e--;
                if (cnt_e == 0) up_e = 1;
            end
        end
        chk(bad_c == 0, "R9 carrier waveform", bad_c, 0);
        chk(bad_g == 0, "R10 gate compare", bad_g, 0);
        chk(highs == 199, "R10 zero-command duty", highs, 199);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_phase = 0; m_int_d = 0; m_int_q = 0;
        t_reset();
        t_strobe();
        t_harmonic();
        t_windup();
        t_full();
        t_carrier();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule